// File: doc/BRIEF.md
# SPI Command/Response Transaction Master

This block is an SPI master that runs one framed exchange with a single serial device. The exchange has two phases: a command phase and a response phase. The host gives a command byte count and a response byte count, then strobes start. The master lowers chip select and shifts out each command byte, taking the bytes from a valid/ready input stream. It then clocks out zero filler bytes, so that the device can return its response bytes. Every byte the device returns during the command phase is dropped. Response bytes leave through a valid/ready output stream. Chip select stays low from the first byte to the last one. When it rises again, a one-cycle done pulse marks the end of the exchange.

Frames are 8 bits long, sent MSB first, in SPI mode 0. The serial clock idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. The serial clock is derived from the system clock by a prescale value and a rate value, both captured when start is accepted. The master moves bytes only at byte boundaries. If the command stream has no byte ready, or the response holding register is still occupied, the master waits between bytes: the serial clock stays low and chip select stays asserted. The stream rules are as follows. A command byte is transferred in a cycle where tx_valid and tx_ready are both high. tx_ready is raised only at a command byte boundary while chip select is low. A response byte stays on rx_data with rx_valid high until rx_ready is seen high. The master does not begin another response byte while one is still waiting.

When the enable input is low, chip select is held high and the bus drive enable is low. Dropping enable during an exchange abandons the exchange.

Top module: `spi_txn_master`

## Requirements
- R1: Each byte is shifted MSB first in mode 0. SCK idles low and is low whenever cs_n is high. MOSI is stable across each rising SCK edge, and MISO is captured on the rising edge.
- R2: SCK high and low phases each last max(floor(prescale/2),1) x (rate+1) clk cycles. So an odd prescale acts as the even value below it, and a prescale of 0 acts as 2. The values are captured when start is accepted.
- R3: cs_n falls once before the first SCK rising edge and rises once after the last byte. It stays low between bytes and during any stall.
- R4: An exchange moves exactly tx_len + rx_len bytes. It ends with a single-cycle done pulse, and cs_n is high in that cycle.
- R5: Bytes received while command bytes are being sent are dropped. Exactly rx_len response bytes are delivered, in the order received.
- R6: During the response phase the master transmits 0x00 filler bytes.
- R7: tx_ready is high only while cs_n is low, at a command byte boundary. The master waits with SCK low until a command byte is offered.
- R8: rx_valid and rx_data hold until rx_ready is high. While a response byte is held, the master starts no new byte and SCK stays low.
- R9: An accepted start discards any response byte still held from an earlier exchange, so rx_valid is low in the following cycle.
- R10: With en low, cs_n is high, bus_oe is low one cycle later, and start is ignored. Dropping en mid-exchange abandons it and raises cs_n.
- R11: A start strobe during a running exchange is ignored, along with any change to its lengths or clock settings.
- R12: A start with tx_len + rx_len = 0 gives done in the next cycle without lowering cs_n.
- R13: tx_len = 0 gives a pure read of rx_len bytes with 0x00 filler from the first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low releases the bus |
| prescale | input | PRE_W | Even clock prescale (>= 2) |
| rate | input | RATE_W | Serial clock rate field; divides by rate+1 |
| tx_len | input | CNT_W | Number of command bytes |
| rx_len | input | CNT_W | Number of response bytes |
| start | input | 1 | Start strobe, sampled in idle |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| tx_data | input | 8 | Command byte stream data |
| tx_valid | input | 1 | Command byte offered |
| tx_ready | output | 1 | Master takes the offered command byte |
| rx_data | output | 8 | Response byte stream data |
| rx_valid | output | 1 | Response byte available |
| rx_ready | input | 1 | Consumer accepts the response byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| bus_oe | output | 1 | Drive enable for sck, mosi and cs_n pads |

## Verification
The assertions check on every cycle that SCK stays low while deselected and that MOSI holds across a rising edge. They also check that a held response byte stays unchanged until taken, that tx_ready appears only under an asserted chip select, and that disabling the port releases the bus. They further check that a running exchange keeps its captured lengths and that the divider count stays inside its period. Only the bench scenarios can show the byte-level results: the order of the MOSI bits, the zero filler, and the dropping of command-phase input bytes. The same holds for the exact SCK phase lengths under different prescale and rate values, the single chip-select window, the flush of a stale response, and the zero-length and pure-read cases.

// File: rtl/spi_txn_pkg.sv
`timescale 1ns/1ps
package spi_txn_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FILL_BYTE = '0;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOAD  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_HOLD  = 3'd4
  } txn_state_t;
endpackage

// File: rtl/spi_sck_div.sv
`timescale 1ns/1ps
module spi_sck_div #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate,
  input  logic              run,
  output logic              tick
);
  localparam int unsigned HALF_W = PRE_W + RATE_W;

  logic [PRE_W-1:0]  pre_sh;
  logic [HALF_W-1:0] pre_eff;
  logic [HALF_W-1:0] rate_eff;
  logic [HALF_W-1:0] half_new;
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;

  always_comb begin
    pre_sh   = prescale >> 1;
    pre_eff  = (pre_sh == '0) ? HALF_W'(1) : HALF_W'(pre_sh);
    rate_eff = HALF_W'(rate) + HALF_W'(1);
    half_new = pre_eff * rate_eff;
  end

  assign tick = run && (cnt_q == half_q - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(1);
      cnt_q  <= '0;
    end else begin
      if (cfg_load) half_q <= half_new;
      if (!run || tick) cnt_q <= '0;
      else              cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  // R2
  div_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_q);
endmodule

// File: rtl/spi_byte_shift.sv
`timescale 1ns/1ps
module spi_byte_shift
  import spi_txn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              tick,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              active,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] tx_sr;
  logic [BYTE_W-1:0] rx_sr;
  logic [CNT_W-1:0]  bit_cnt;

  assign rx_byte = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr     <= '0;
      rx_sr     <= '0;
      bit_cnt   <= '0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      active    <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        sck    <= 1'b0;
      end else if (load) begin
        tx_sr   <= load_byte;
        mosi    <= load_byte[BYTE_W-1];
        bit_cnt <= '0;
        sck     <= 1'b0;
        active  <= 1'b1;
      end else if (active && tick) begin
        if (!sck) begin
          sck   <= 1'b1;
          rx_sr <= {rx_sr[BYTE_W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
            mosi    <= tx_sr[BYTE_W-2];
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  // R1
  mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
  // R1
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !sck);
endmodule

// File: rtl/spi_rx_hold.sv
`timescale 1ns/1ps
module spi_rx_hold
  import spi_txn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              empty
);
  assign empty = !out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8
  rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_data));
  // R9
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: rtl/spi_txn_ctrl.sv
`timescale 1ns/1ps
module spi_txn_ctrl
  import spi_txn_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic [CNT_W-1:0]  rx_len,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              tick,
  input  logic              sh_active,
  input  logic              sh_done,
  output logic              sh_load,
  output logic [BYTE_W-1:0] sh_byte,
  output logic              cfg_load,
  output logic              div_run,
  output logic              rx_push,
  input  logic              rx_empty,
  output logic              rx_flush,
  output logic              cs_n,
  output logic              busy,
  output logic              done
);
  localparam int unsigned TOT_W = CNT_W + 1;

  txn_state_t       state_q;
  logic [TOT_W-1:0] total_q;
  logic [TOT_W-1:0] txlen_q;
  logic [TOT_W-1:0] idx_q;
  logic [TOT_W-1:0] idx_nxt;
  logic [TOT_W-1:0] total_in;
  logic             resp_q;
  logic             in_cmd;
  logic             accept;
  logic             fire_cmd;
  logic             fire_resp;

  always_comb begin
    total_in  = {1'b0, tx_len} + {1'b0, rx_len};
    idx_nxt   = idx_q + TOT_W'(1);
    in_cmd    = idx_q < txlen_q;
    accept    = en && (state_q == ST_IDLE) && start;
    tx_ready  = en && (state_q == ST_LOAD) && in_cmd;
    fire_cmd  = tx_ready && tx_valid;
    fire_resp = en && (state_q == ST_LOAD) && !in_cmd && rx_empty;
    sh_load   = fire_cmd || fire_resp;
    sh_byte   = fire_cmd ? tx_data : FILL_BYTE;
    cfg_load  = accept;
    rx_flush  = accept;
    rx_push   = (state_q == ST_SHIFT) && sh_done && resp_q;
    div_run   = (state_q == ST_SETUP) || (state_q == ST_HOLD) || sh_active;
    cs_n      = (state_q == ST_IDLE);
    busy      = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      total_q <= '0;
      txlen_q <= '0;
      idx_q   <= '0;
      resp_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start) begin
            txlen_q <= {1'b0, tx_len};
            total_q <= total_in;
            idx_q   <= '0;
            if (total_in == '0) done    <= 1'b1;
            else                state_q <= ST_SETUP;
          end
          ST_SETUP: if (tick) state_q <= ST_LOAD;
          ST_LOAD: if (sh_load) begin
            resp_q  <= fire_resp;
            state_q <= ST_SHIFT;
          end
          ST_SHIFT: if (sh_done) begin
            idx_q   <= idx_nxt;
            state_q <= (idx_nxt == total_q) ? ST_HOLD : ST_LOAD;
          end
          ST_HOLD: if (tick) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  tx_ready_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !cs_n);
  // R4
  done_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(total_q) && $stable(txlen_q));
  // R12
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (total_in == '0) |=> done && cs_n);
endmodule

// File: rtl/spi_txn_master.sv
`timescale 1ns/1ps
module spi_txn_master
  import spi_txn_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic [CNT_W-1:0]  rx_len,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic [7:0]        tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic              bus_oe
);
  logic              tick;
  logic              cfg_load;
  logic              div_run;
  logic              sh_load;
  logic [BYTE_W-1:0] sh_byte;
  logic              sh_active;
  logic              sh_done;
  logic [BYTE_W-1:0] sh_rx;
  logic              rx_push;
  logic              rx_empty;
  logic              rx_flush;

  spi_sck_div #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .prescale(prescale),
    .rate(rate), .run(div_run), .tick(tick)
  );

  spi_byte_shift u_shift (
    .clk(clk), .rst_n(rst_n), .abort(!en), .load(sh_load), .load_byte(sh_byte),
    .tick(tick), .miso(miso), .sck(sck), .mosi(mosi), .active(sh_active),
    .byte_done(sh_done), .rx_byte(sh_rx)
  );

  spi_rx_hold u_rxh (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
    .push_data(sh_rx), .out_valid(rx_valid), .out_data(rx_data),
    .out_ready(rx_ready), .empty(rx_empty)
  );

  spi_txn_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .tx_len(tx_len),
    .rx_len(rx_len), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tick(tick), .sh_active(sh_active),
    .sh_done(sh_done), .sh_load(sh_load), .sh_byte(sh_byte),
    .cfg_load(cfg_load), .div_run(div_run), .rx_push(rx_push),
    .rx_empty(rx_empty), .rx_flush(rx_flush), .cs_n(cs_n), .busy(busy),
    .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_oe <= 1'b0;
    else        bus_oe <= en;
  end

  // R3
  sck_deselected_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R10
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cs_n && !bus_oe);
  // R8
  stall_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !sck && !rx_flush |=> !$rose(sck) || !rx_valid || !busy);
endmodule

// File: tb/spi_txn_master_tb.sv
`timescale 1ns/1ps
module spi_txn_master_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, en, start, tx_valid, rx_ready, miso;
  logic [7:0] prescale, rate, tx_len, rx_len, tx_data;
  logic       busy, done, tx_ready, rx_valid, sck, mosi, cs_n, bus_oe;
  logic [7:0] rx_data;

  spi_txn_master u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .prescale(prescale), .rate(rate),
    .tx_len(tx_len), .rx_len(rx_len), .start(start), .busy(busy), .done(done),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_n(cs_n), .bus_oe(bus_oe)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, done_cnt = 0;
  int cs_falls = 0, cs_rises = 0, half_err = 0, half_exp = 1, rise_cyc = 0;
  int rx_mode = 0;
  int in_bits = 0;
  bit gap_mode = 0, tx_fired = 0, en_samp = 0, sck_p = 0, cs_p = 1;
  logic [7:0] tx_feed[$], slave_q[$], mosi_log[$], got_rx[$];
  logic [7:0] in_sr, out_sr;
  int s_idx = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor at the active edge: sample handshakes with pre-edge values
  always @(posedge clk) begin
    cyc++;
    en_samp = en;
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        tx_fired = 1;
        if (tx_feed.size() > 0) void'(tx_feed.pop_front());
      end
      if (rx_valid && rx_ready) got_rx.push_back(rx_data);
      if (done) done_cnt++;
    end
  end

  // drivers, reference slave and per-cycle checks away from the edge
  always @(negedge clk) begin
    if (tx_fired) begin tx_valid = 0; tx_fired = 0; end
    if (tx_feed.size() == 0) tx_valid = 0;
    else if (!tx_valid && (!gap_mode || (cyc % 3 == 0))) begin
      tx_valid = 1; tx_data = tx_feed[0];
    end
    rx_ready = (rx_mode == 1) ? 1'b1 : (rx_mode == 2) ? (cyc % 5 == 0) : 1'b0;
    if (rst_n) begin
      chk(!(cs_n && sck), "R3 sck low while deselected", sck, 0);
      chk(bus_oe == en_samp, "R10 bus drive tracks enable", bus_oe, en_samp);
      if (done) chk(cs_n, "R4 cs high at done", cs_n, 1);
      if (cs_n) in_bits = 0;
      if (cs_p && !cs_n) begin
        cs_falls++;
        out_sr = (s_idx < slave_q.size()) ? slave_q[s_idx] : 8'hFF; s_idx++;
        miso = out_sr[7];
      end
      if (!cs_p && cs_n) cs_rises++;
      if (!sck_p && sck) begin
        chk(!cs_n, "R3 cs low at sck rise", cs_n, 0);
        in_sr = {in_sr[6:0], mosi}; in_bits++; rise_cyc = cyc;
        if (in_bits == 8) begin mosi_log.push_back(in_sr); in_bits = 0; end
      end
      if (sck_p && !sck) begin
        if (cyc - rise_cyc != half_exp) begin
          half_err++;
          $display("  phase length %0d vs %0d", cyc - rise_cyc, half_exp);
        end
        if (in_bits == 0) begin
          out_sr = (s_idx < slave_q.size()) ? slave_q[s_idx] : 8'hFF; s_idx++;
        end else out_sr = {out_sr[6:0], 1'b0};
        miso = out_sr[7];
      end
      sck_p = sck; cs_p = cs_n;
    end
  end

  task automatic txn_begin(input logic [7:0] cmd[$], input int rlen, input int pre,
                           input int rt, input bit gap, input int seed);
    int tot;
    @(negedge clk);
    rx_mode = 0;
    tot = cmd.size() + rlen;
    prescale = 8'(pre); rate = 8'(rt); tx_len = 8'(cmd.size()); rx_len = 8'(rlen);
    half_exp = ((pre / 2) < 1 ? 1 : pre / 2) * (rt + 1);
    tx_feed = cmd; gap_mode = gap;
    slave_q.delete();
    for (int i = 0; i < tot; i++) slave_q.push_back(8'(8'h3C ^ (i * 29 + seed)));
    s_idx = 0; mosi_log.delete(); got_rx.delete();
    cs_falls = 0; cs_rises = 0; half_err = 0;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(rx_valid == 0, "R9 held response flushed by start", rx_valid, 0);
  endtask

  task automatic txn_finish(input logic [7:0] cmd[$], input int rlen, input int mode,
                            input int d0, input string tg);
    int tot;
    tot = cmd.size() + rlen;
    rx_mode = mode;
    for (int t = 0; t < 30000 && done_cnt == d0; t++) @(negedge clk);
    chk(done_cnt == d0 + 1, {"R4 one done pulse ", tg}, done_cnt - d0, 1);
    for (int t = 0; t < 400 && got_rx.size() < rlen && mode != 0; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(mosi_log.size() == tot, {"R4 byte count ", tg}, mosi_log.size(), tot);
    for (int i = 0; i < tot && i < mosi_log.size(); i++) begin
      if (i < cmd.size()) chk(mosi_log[i] == cmd[i], {"R1 command bits ", tg}, mosi_log[i], cmd[i]);
      else chk(mosi_log[i] == 8'h00, {"R6 zero filler ", tg}, mosi_log[i], 0);
    end
    if (mode != 0) begin
      chk(got_rx.size() == rlen, {"R5 response count ", tg}, got_rx.size(), rlen);
      for (int k = 0; k < rlen && k < got_rx.size(); k++)
        chk(got_rx[k] == slave_q[cmd.size() + k], {"R5 response data ", tg},
            got_rx[k], slave_q[cmd.size() + k]);
    end
    chk(half_err == 0, {"R2 sck phase length ", tg}, half_err, 0);
    chk(cs_falls == 1 && cs_rises == 1, {"R3 single cs window ", tg}, cs_falls * 10 + cs_rises, 11);
    chk(busy == 0, {"R4 idle after done ", tg}, busy, 0);
  endtask

  initial begin
    int d0;
    logic [7:0] c[$];
    rst_n = 0; en = 0; start = 0; tx_valid = 0; rx_ready = 0; miso = 0;
    prescale = 2; rate = 0; tx_len = 0; rx_len = 0; tx_data = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sck == 0 && busy == 0 && done == 0, "R10 reset idle", {cs_n, sck, busy, done}, 8);
    chk(rx_valid == 0 && tx_ready == 0 && bus_oe == 0, "R10 reset streams", {rx_valid, tx_ready, bus_oe}, 0);
    en = 1;
    repeat (2) @(negedge clk);

    c = '{8'h90, 8'h00, 8'h00, 8'h00};
    d0 = done_cnt; txn_begin(c, 2, 2, 0, 0, 1); txn_finish(c, 2, 1, d0, "id-read");

    c = '{8'h9F};
    d0 = done_cnt; txn_begin(c, 3, 4, 1, 0, 7); txn_finish(c, 3, 1, d0, "half4");

    // command gaps and response back-pressure pattern
    c = '{8'h4B, 8'h00, 8'h00, 8'h00, 8'h00};
    d0 = done_cnt; txn_begin(c, 8, 2, 2, 1, 3); txn_finish(c, 8, 2, d0, "R7 R8 stalls");

    // R13 pure read
    c = {};
    d0 = done_cnt; txn_begin(c, 4, 6, 0, 0, 11); txn_finish(c, 4, 1, d0, "R13 pure read");

    // command only, odd prescale acts as 2
    c = '{8'hA5, 8'h5A, 8'hFF};
    d0 = done_cnt; txn_begin(c, 0, 3, 0, 0, 5); txn_finish(c, 0, 1, d0, "R2 odd prescale");

    // R11 start while busy is ignored
    c = '{8'h05};
    d0 = done_cnt; txn_begin(c, 2, 2, 1, 0, 9);
    repeat (12) @(negedge clk);
    tx_len = 3; rx_len = 7; prescale = 8; start = 1;
    @(negedge clk); start = 0;
    txn_finish(c, 2, 1, d0, "R11 busy start");

    // R8 held response: master stalls with sck low and cs asserted
    c = '{8'h35};
    d0 = done_cnt; txn_begin(c, 2, 2, 0, 0, 21);
    rx_mode = 0;
    for (int t = 0; t < 2000 && !rx_valid; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int t = 0; t < 40; t++) begin
      if (sck || cs_n || !busy) begin
        chk(0, "R8 stall keeps sck low under cs", {sck, cs_n, busy}, 1);
        break;
      end
      @(negedge clk);
    end
    chk(rx_valid && rx_data == slave_q[1], "R8 held response byte", rx_data, slave_q[1]);
    txn_finish(c, 2, 1, d0, "R8 released");

    // R9 leave a byte pending, then start again
    c = '{8'h05};
    d0 = done_cnt; txn_begin(c, 1, 2, 0, 0, 33);
    for (int t = 0; t < 3000 && done_cnt == d0; t++) @(negedge clk);
    @(negedge clk);
    chk(rx_valid == 1 && rx_data == slave_q[1], "R8 pending after done", rx_data, slave_q[1]);
    c = '{8'h66};
    d0 = done_cnt; txn_begin(c, 2, 2, 0, 0, 40); txn_finish(c, 2, 1, d0, "R9 after flush");

    // R12 zero total length
    @(negedge clk);
    rx_mode = 1; d0 = done_cnt; tx_len = 0; rx_len = 0; cs_falls = 0;
    start = 1; @(negedge clk); start = 0;
    chk(done == 1, "R12 done next cycle", done, 1);
    repeat (5) @(negedge clk);
    chk(cs_falls == 0 && done_cnt == d0 + 1, "R12 cs never low", cs_falls, 0);

    // R10 abort by disable, then start ignored while disabled
    c = '{8'h01, 8'h02, 8'h03};
    d0 = done_cnt; txn_begin(c, 2, 4, 0, 0, 50);
    repeat (30) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(cs_n == 1 && bus_oe == 0 && busy == 0, "R10 abort releases bus", {cs_n, bus_oe, busy}, 4);
    tx_feed.delete();
    tx_len = 1; rx_len = 1; start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    chk(busy == 0 && cs_n == 1 && done_cnt == d0, "R10 start ignored when disabled", busy, 0);
    en = 1;
    repeat (3) @(negedge clk);
    c = '{8'h0B, 8'h10};
    d0 = done_cnt; txn_begin(c, 3, 2, 0, 0, 60); txn_finish(c, 3, 1, d0, "R10 recovery");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule